// File: doc/BRIEF.md
# Descriptor-Table Scatter-Gather DMA Walker

This block moves one transfer of N bytes between a local byte buffer and system memory. The memory side of the transfer is described by a table of 8-byte region descriptors that lives in system memory. On a start pulse the walker latches the table base, the byte count and the direction. It then alternates between fetching a descriptor and issuing data bursts against the region that descriptor names, until the buffer is consumed, the table runs out, or the memory reports an error.

Descriptors are fetched through a dedicated read port, one 64-bit handshake per descriptor. Data bursts go through a second port. Each burst carries a memory address, a byte length, a local-buffer index and a write-enable. The agent behind that port moves the bytes between the buffer and memory. Every access on either port is a request held until an acknowledge, and the acknowledge may carry an error response.

The outcome is reported on three sticky flags (done, table exhausted, error). The flags are cleared by the next accepted start.

Top module: `sg_walker`

## Requirements
- R1: A start pulse while idle latches base, byte count and direction, clears all outcome flags and raises busy on the next cycle. A byte count of zero ends in done with no memory access at all.
- R2: Descriptors are read one per handshake on the descriptor port. The first read is at the base and each further read is 8 bytes above the previous one. The 64-bit word carries the region address in bits 31:0 and the size word in bits 63:32.
- R3: The region length is size word AND 0xFFFE, so bit 0 is ignored. A masked length of zero means 65536 bytes.
- R4: Bit 31 of the size word (bit 63 of the descriptor) marks the final descriptor. No descriptor is fetched after the region it describes is used up.
- R5: Each burst length is the minimum of the buffer bytes left, the region bytes left and MAX_BURST. After an accepted burst, the region address and the buffer index both advance by that length, so the next burst starts where the previous one ended.
- R6: dat_we_o is 1 for buffer-to-memory and 0 for memory-to-buffer on every burst of the transfer, following the latched direction.
- R7: When the buffer count is fully consumed the walker raises done and goes idle without fetching another descriptor. This buffer check takes priority over the table checks.
- R8: When a region is used up with buffer bytes still left, the walker raises table-exhausted if the final marker was seen. It also raises table-exhausted if the table pointer has reached TABLE_SPAN (4096) bytes past the base.
- R9: An acknowledge with the error response on either port sets error, returns the walker to idle and ends all requests.
- R10: At most one port requests at a time. A request and its address, length and index stay stable until acknowledged.
- R11: A start pulse while busy has no effect on the ongoing walk.
- R12: At most one outcome flag is set at a time. The flags hold their value while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| dir_to_mem_i | input | 1 | 1: buffer to memory, 0: memory to buffer |
| tbl_base_i | input | 32 | Descriptor table base address |
| xfer_bytes_i | input | BCNT_W | Bytes to move |
| dsc_req_o | output | 1 | Descriptor fetch request |
| dsc_addr_o | output | 32 | Descriptor address |
| dsc_ack_i | input | 1 | Descriptor fetch acknowledge |
| dsc_err_i | input | 1 | Error response with acknowledge |
| dsc_data_i | input | 64 | Descriptor word, valid with acknowledge |
| dat_req_o | output | 1 | Data burst request |
| dat_we_o | output | 1 | Burst writes memory |
| dat_addr_o | output | 32 | Burst memory address |
| dat_len_o | output | LEN_W | Burst length in bytes |
| dat_buf_idx_o | output | BCNT_W | Local buffer index of the burst |
| dat_ack_i | input | 1 | Burst acknowledge |
| dat_err_i | input | 1 | Error response with acknowledge |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Buffer fully moved |
| exhausted_o | output | 1 | Table ended before the buffer was moved |
| err_o | output | 1 | Walk aborted by an error response |

## Verification
A corrupted region count or address shows up at the very next burst request, because the burst's length or address no longer matches the reference order of accesses. A stale table pointer or a lost final marker shows up as a descriptor fetch at an address the reference never issues, or as a missing fetch. Either way it is caught in the cycle the request appears, not at the end of the transfer. A wrong buffer index or a wrong priority between the end checks changes the outcome flag or the burst index, and this is seen within one handshake.

// File: rtl/sg_walker_pkg.sv
package sg_walker_pkg;
  localparam int unsigned AW       = 32;
  localparam int unsigned REGION_W = 17;  // up to 65536

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_FETCH, ST_BURST} walk_state_e;

  typedef struct packed {
    logic                last;
    logic [REGION_W-1:0] len;
    logic [AW-1:0]       addr;
  } region_t;
endpackage

// File: rtl/sg_dsc_decode.sv
module sg_dsc_decode
  import sg_walker_pkg::*;
(
  input  logic [63:0] raw_i,
  output region_t     region_o
);
  logic [15:0] masked;
  assign masked          = raw_i[47:32] & 16'hFFFE;
  assign region_o.addr   = raw_i[31:0];
  assign region_o.last   = raw_i[63];
  assign region_o.len    = (masked == 16'd0) ? REGION_W'(65536) : REGION_W'(masked);
endmodule

// File: rtl/sg_burst_calc.sv
module sg_burst_calc
  import sg_walker_pkg::*;
#(
  parameter int unsigned BCNT_W    = 20,
  parameter int unsigned MAX_BURST = 512,
  parameter int unsigned LEN_W     = 10
) (
  input  logic [BCNT_W-1:0]   buf_left_i,
  input  logic [REGION_W-1:0] reg_left_i,
  output logic [LEN_W-1:0]    len_o
);
  localparam int unsigned CW = (BCNT_W > REGION_W) ? BCNT_W : REGION_W;
  logic [CW-1:0] a, b, m;
  always_comb begin
    a = CW'(buf_left_i);
    b = CW'(reg_left_i);
    m = (a < b) ? a : b;
    if (m > CW'(MAX_BURST)) m = CW'(MAX_BURST);
    len_o = LEN_W'(m);
  end
endmodule

// File: rtl/sg_table_guard.sv
module sg_table_guard
  import sg_walker_pkg::*;
#(
  parameter int unsigned TABLE_SPAN = 4096
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] cur_i,
  output logic          at_limit_o
);
  logic [AW-1:0] offset;
  assign offset     = cur_i - base_i;
  assign at_limit_o = offset >= AW'(TABLE_SPAN);
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sg_walker_pkg::*;
#(
  parameter int unsigned BCNT_W     = 20,
  parameter int unsigned MAX_BURST  = 512,
  parameter int unsigned TABLE_SPAN = 4096,
  localparam int unsigned LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_to_mem_i,
  input  logic [31:0]       tbl_base_i,
  input  logic [BCNT_W-1:0] xfer_bytes_i,
  output logic              dsc_req_o,
  output logic [31:0]       dsc_addr_o,
  input  logic              dsc_ack_i,
  input  logic              dsc_err_i,
  input  logic [63:0]       dsc_data_i,
  output logic              dat_req_o,
  output logic              dat_we_o,
  output logic [31:0]       dat_addr_o,
  output logic [LEN_W-1:0]  dat_len_o,
  output logic [BCNT_W-1:0] dat_buf_idx_o,
  input  logic              dat_ack_i,
  input  logic              dat_err_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              exhausted_o,
  output logic              err_o
);
  walk_state_e       state_q;
  logic [AW-1:0]     base_q, tbl_q;
  region_t           reg_q, dec;
  logic [BCNT_W-1:0] total_q, idx_q, buf_left;
  logic              we_q, done_q, exh_q, err_q;
  logic [LEN_W-1:0]  burst_len;
  logic              at_limit;

  assign buf_left = total_q - idx_q;

  sg_dsc_decode u_dec (.raw_i(dsc_data_i), .region_o(dec));

  sg_burst_calc #(.BCNT_W(BCNT_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)) u_burst (
    .buf_left_i(buf_left), .reg_left_i(reg_q.len), .len_o(burst_len));

  sg_table_guard #(.TABLE_SPAN(TABLE_SPAN)) u_guard (
    .base_i(base_q), .cur_i(tbl_q), .at_limit_o(at_limit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      tbl_q   <= '0;
      reg_q   <= '0;
      total_q <= '0;
      idx_q   <= '0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      exh_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          base_q  <= tbl_base_i;
          tbl_q   <= tbl_base_i;
          reg_q   <= '0;
          total_q <= xfer_bytes_i;
          idx_q   <= '0;
          we_q    <= dir_to_mem_i;
          done_q  <= 1'b0;
          exh_q   <= 1'b0;
          err_q   <= 1'b0;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          // buffer end wins over table end
          if (buf_left == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (reg_q.len == '0) begin
            if (reg_q.last || at_limit) begin
              exh_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_FETCH;
            end
          end else begin
            state_q <= ST_BURST;
          end
        end
        ST_FETCH: if (dsc_ack_i) begin
          if (dsc_err_i) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            reg_q   <= dec;
            tbl_q   <= tbl_q + AW'(8);
            state_q <= ST_CHECK;
          end
        end
        ST_BURST: if (dat_ack_i) begin
          if (dat_err_i) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            reg_q.addr <= reg_q.addr + AW'(burst_len);
            reg_q.len  <= reg_q.len - REGION_W'(burst_len);
            idx_q      <= idx_q + BCNT_W'(burst_len);
            state_q    <= ST_CHECK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dsc_req_o     = state_q == ST_FETCH;
  assign dsc_addr_o    = tbl_q;
  assign dat_req_o     = state_q == ST_BURST;
  assign dat_we_o      = we_q;
  assign dat_addr_o    = reg_q.addr;
  assign dat_len_o     = burst_len;
  assign dat_buf_idx_o = idx_q;
  assign busy_o        = state_q != ST_IDLE;
  assign done_o        = done_q;
  assign exhausted_o   = exh_q;
  assign err_o         = err_q;
endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
  parameter int unsigned BCNT_W    = 20,
  parameter int unsigned MAX_BURST = 512,
  parameter int unsigned LEN_W     = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              dsc_req_o,
  input logic [31:0]       dsc_addr_o,
  input logic              dsc_ack_i,
  input logic              dsc_err_i,
  input logic              dat_req_o,
  input logic              dat_we_o,
  input logic [31:0]       dat_addr_o,
  input logic [LEN_W-1:0]  dat_len_o,
  input logic [BCNT_W-1:0] dat_buf_idx_o,
  input logic              dat_ack_i,
  input logic              dat_err_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              exhausted_o,
  input logic              err_o
);
  assert_one_port_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dsc_req_o && dat_req_o));

  assert_dsc_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsc_req_o && !dsc_ack_i |=> dsc_req_o && $stable(dsc_addr_o));

  assert_dat_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_req_o && !dat_ack_i |=> dat_req_o && $stable(dat_addr_o)
      && $stable(dat_len_o) && $stable(dat_buf_idx_o) && $stable(dat_we_o));

  assert_len_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_req_o |-> dat_len_o != '0 && dat_len_o <= LEN_W'(MAX_BURST));

  assert_idx_advance_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_req_o && dat_ack_i && !dat_err_i |=>
      dat_buf_idx_o == $past(dat_buf_idx_o) + BCNT_W'($past(dat_len_o)));

  assert_flags_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, exhausted_o, err_o}));

  assert_flags_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable({done_o, exhausted_o, err_o}));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !dsc_req_o && !dat_req_o);

  assert_dat_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_req_o && dat_ack_i && dat_err_i |=> !busy_o && err_o);

  assert_dsc_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsc_req_o && dsc_ack_i && dsc_err_i |=> !busy_o && err_o);

  assert_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o && !done_o && !exhausted_o && !err_o);
endmodule

bind sg_walker sg_walker_chk #(.BCNT_W(BCNT_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/sg_walker_test.sv
`timescale 1ns/1ps
module sg_walker_test;
  localparam int BCNT_W = 20;
  localparam int MAXB   = 512;
  localparam int LEN_W  = $clog2(MAXB + 1);
  localparam int SPAN   = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              start = 0, dir = 0;
  logic [31:0]       base = 0;
  logic [BCNT_W-1:0] nbytes = 0;
  logic              dsc_req, dsc_ack = 0, dsc_err = 0;
  logic [31:0]       dsc_addr;
  logic [63:0]       dsc_data = 0;
  logic              dat_req, dat_we, dat_ack = 0, dat_err = 0;
  logic [31:0]       dat_addr;
  logic [LEN_W-1:0]  dat_len;
  logic [BCNT_W-1:0] dat_idx;
  logic              busy, done, exh, err;

  sg_walker #(.BCNT_W(BCNT_W), .MAX_BURST(MAXB), .TABLE_SPAN(SPAN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_to_mem_i(dir),
    .tbl_base_i(base), .xfer_bytes_i(nbytes),
    .dsc_req_o(dsc_req), .dsc_addr_o(dsc_addr), .dsc_ack_i(dsc_ack),
    .dsc_err_i(dsc_err), .dsc_data_i(dsc_data),
    .dat_req_o(dat_req), .dat_we_o(dat_we), .dat_addr_o(dat_addr),
    .dat_len_o(dat_len), .dat_buf_idx_o(dat_idx), .dat_ack_i(dat_ack),
    .dat_err_i(dat_err), .busy_o(busy), .done_o(done), .exhausted_o(exh),
    .err_o(err));

  typedef struct {
    bit          is_dsc;
    int unsigned addr;
    int unsigned len;
    bit          we;
    int unsigned idx;
  } acc_t;

  logic [63:0] mem [int unsigned];
  acc_t        exp_q[$];
  int          n_cmp = 0, n_bad = 0;
  int          dsc_err_at = -1, dat_err_at = -1, n_dsc_seen = 0, n_dat_seen = 0;
  int          wait_ctr = 0, hs = 0;
  string       cur_req = "";

  task automatic chk(string req, longint act, longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference: expected access order and outcome (0 done, 1 exhausted, 2 error)
  task automatic model(input int unsigned b, input int unsigned n, input bit we,
                       output int outcome);
    int unsigned cur = b, raddr = 0, rlen = 0, idx = 0, l;
    bit last = 0;
    int nd = 0, nb = 0;
    logic [63:0] w;
    acc_t a;
    exp_q.delete();
    forever begin
      if (idx == n) begin outcome = 0; return; end
      if (rlen == 0) begin
        if (last || (cur - b) >= SPAN) begin outcome = 1; return; end
        a = '{1, cur, 0, 0, 0};
        exp_q.push_back(a);
        if (nd == dsc_err_at) begin outcome = 2; return; end
        nd++;
        w = mem.exists(cur) ? mem[cur] : 64'h0;
        raddr = w[31:0];
        rlen = int'(w[47:32] & 16'hFFFE);
        if (rlen == 0) rlen = 65536;
        last = w[63];
        cur += 8;
        continue;
      end
      l = n - idx;
      if (rlen < l) l = rlen;
      if (MAXB < l) l = MAXB;
      a = '{0, raddr, l, we, idx};
      exp_q.push_back(a);
      if (nb == dat_err_at) begin outcome = 2; return; end
      nb++;
      raddr += l; rlen -= l; idx += l;
    end
  endtask

  // responder and per-clock comparison against the expected access order
  initial forever begin
    @(negedge clk);
    if (dsc_ack || dat_ack) begin
      dsc_ack = 0; dsc_err = 0; dat_ack = 0; dat_err = 0; dsc_data = 0;
    end else if (dsc_req || dat_req) begin
      if (exp_q.size() == 0) begin
        chk({cur_req, " unexpected request"}, {dsc_req, dat_req}, 0);
      end else begin
        chk({cur_req, " R2 port order"}, dsc_req, exp_q[0].is_dsc);
        if (dsc_req) chk({cur_req, " R2 dsc addr"}, dsc_addr, exp_q[0].addr);
        else begin
          chk({cur_req, " R5 burst addr"}, dat_addr, exp_q[0].addr);
          chk({cur_req, " R5 burst len"}, dat_len, exp_q[0].len);
          chk({cur_req, " R5 buf idx"}, dat_idx, exp_q[0].idx);
          chk({cur_req, " R6 direction"}, dat_we, exp_q[0].we);
        end
        if (wait_ctr == 0) begin
          if (dsc_req) begin
            dsc_ack = 1;
            dsc_err = (n_dsc_seen == dsc_err_at);
            dsc_data = mem.exists(dsc_addr) ? mem[dsc_addr] : 64'h0;
            n_dsc_seen++;
          end else begin
            dat_ack = 1;
            dat_err = (n_dat_seen == dat_err_at);
            n_dat_seen++;
          end
          void'(exp_q.pop_front());
          hs++;
          wait_ctr = hs % 3;
        end else wait_ctr--;
      end
    end
  end

  task automatic run(string tag, input int unsigned b, input int unsigned n,
                     input bit we, input bit restart);
    int outcome, cyc = 0;
    logic [2:0] exp_f;
    cur_req = tag;
    n_dsc_seen = 0; n_dat_seen = 0;
    model(b, n, we, outcome);
    @(negedge clk);
    base = b; nbytes = BCNT_W'(n); dir = we; start = 1;
    @(negedge clk);
    start = 0;
    chk({tag, " R1 busy after start"}, busy, n == 0 ? busy : 1);
    if (restart) begin
      repeat (3) @(negedge clk);
      base = b + 32'h100; nbytes = 5; dir = ~we; start = 1;  // R11
      @(negedge clk);
      start = 0;
    end
    while (busy && cyc < 50000) begin @(negedge clk); cyc++; end
    if (busy) chk({tag, " watchdog"}, 1, 0);
    @(negedge clk);
    exp_f = (outcome == 0) ? 3'b100 : (outcome == 1) ? 3'b010 : 3'b001;
    chk({tag, " outcome flags"}, {done, exh, err}, exp_f);
    chk({tag, " all expected accesses seen"}, exp_q.size(), 0);
    chk({tag, " R10 ports quiet"}, {dsc_req, dat_req}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R12 reset flags", {done, exh, err}, 0);
    chk("R10 reset requests", {dsc_req, dat_req}, 0);
    rst_n = 1;
    @(negedge clk);

    // single final descriptor of 1000 bytes
    mem[32'h1000] = {32'h8000_03E8, 32'h0002_0000};
    run("R5 R6 R7 split 1000", 32'h1000, 1000, 1, 0);
    run("R4 R8 final marker", 32'h1000, 1500, 1, 0);

    // odd size bit ignored, zero size means 64 KiB
    mem[32'h2004] = {32'h0000_0101, 32'h0003_0000};
    mem[32'h200C] = {32'h8000_0000, 32'h0004_0000};
    run("R3 R6 read two regions", 32'h2004, 600, 0, 0);
    mem[32'h3000] = {32'h8000_0000, 32'h0010_0000};
    run("R3 R8 64KiB region", 32'h3000, 70000, 1, 0);

    // table of 512 small regions with no final marker, plus one beyond the page
    for (int i = 0; i < 512; i++)
      mem[32'h1_0000 + 8*i] = {32'h0000_0002, 32'h0050_0000 + 32'(16*i)};
    mem[32'h1_0000 + SPAN] = {32'h8000_0010, 32'h0060_0000};
    run("R2 R8 page limit", 32'h1_0000, 2000, 0, 0);

    run("R1 R7 zero count", 32'h1000, 0, 1, 0);

    dsc_err_at = 1;
    run("R9 descriptor error", 32'h2004, 600, 0, 0);
    dsc_err_at = -1; dat_err_at = 1;
    run("R9 data error", 32'h1000, 1000, 1, 0);
    dat_err_at = -1;
    run("R11 start while busy", 32'h1000, 1000, 1, 1);
    run("R12 after restart", 32'h2004, 300, 1, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule